// File: doc/BRIEF.md
# TLB Maintenance Access Trap Arbiter

This block decides what happens when a core issues a 32-bit coprocessor write that requests invalidation of address-translation cache entries tagged with an address-space identifier. A requester presents the decoded coprocessor fields, the operand, the current exception level and the hypervisor state along with its trap controls. One clock later the block returns exactly one verdict. The verdict is one of four: the encoding is not this operation, the operation is undefined, the operation traps to the hypervisor (reported in either the 64-bit or the 32-bit hypervisor style), or the operation executes.

On the execute path the block also returns what the invalidation engine downstream needs. That is the translation regime, whether a virtual-machine identifier qualifies the match and which one, whether entries marked as exempt from the extended-sync attribute are left alone, and the address-space identifier taken from the operand. On a trap it returns which control caused it and the syndrome code. Exception entry and the storage of the control registers are handled elsewhere.

Top module: `tlbm_access_arb`

## Requirements
- R1: When the fields (coproc, opc1, CRn, CRm, opc2) differ from (4'b1111, 3'b000, 4'b1000, 4'b0011, 3'b010), the response has kind 0 (no match) and trap source, syndrome, regime, VMID-valid, VMID and exclude flag all at 0. The other kind codes are 1 undefined, 2 trap in 64-bit style, 3 trap in 32-bit style and 4 execute.
- R2: A matching request at exception level 0 gives kind 1, whatever the hypervisor inputs are.
- R3: At level 1 the trap controls are tested in fixed priority, and the first one set wins. The order is trap_ctl_i bit 0 (coprocessor trap, 64-bit hypervisor), bit 1 (coprocessor trap, 32-bit hypervisor), bit 2 (TLB trap, 64-bit), bit 3 (inner-shareable TLB trap, 64-bit), bit 4 (TLB trap, 32-bit) and bit 5 (inner-shareable TLB trap, 32-bit). trap_src_o reports the winning bit index plus 1. Bits 0, 2 and 3 give kind 2, and bits 1, 4 and 5 give kind 3.
- R4: A trap control has no effect when the hypervisor is disabled, and no effect when hyp_is32_i (1 means a 32-bit hypervisor) does not match that control's style. In either case the request executes.
- R5: Every trap response carries syndrome 0x03. Every other response carries syndrome 0.
- R6: A request that executes at level 1 gives regime 1 (lower), with VMID-valid set and vmid_o equal to vmid_i. The exclude flag is 1 only when all of these hold: xs_feat_i, ext_ctl_feat_i, ext_ctl_en_i and no_xs_ctl_i are set, and hyp_is32_i is 0.
- R7: A matching request at level 2 executes with regime 1, VMID-valid set, vmid_o equal to vmid_i and exclude flag 0, whatever the trap controls are.
- R8: A matching request at level 3 executes with regime 2 (highest level), with VMID-valid at 0, vmid_o at 0 and exclude flag 0.
- R9: rsp_valid_o pulses for one cycle in the cycle after each req_valid_i. asid_o carries operand bits [7:0] on a match and 0 otherwise. All response fields hold their values between requests.
- R10: After reset, rsp_valid_o and every response field are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| coproc_i | input | 4 | Coprocessor number field |
| opc1_i | input | 3 | First opcode field |
| crn_i | input | 4 | Primary register field |
| crm_i | input | 4 | Secondary register field |
| opc2_i | input | 3 | Second opcode field |
| operand_i | input | 32 | Source operand; low bits are the address-space identifier |
| cur_el_i | input | 2 | Current exception level |
| hyp_en_i | input | 1 | Hypervisor level enabled |
| hyp_is32_i | input | 1 | Hypervisor runs in 32-bit state |
| trap_ctl_i | input | 6 | Hypervisor trap controls, bit order as in R3 |
| xs_feat_i | input | 1 | Extended-sync attribute feature present |
| ext_ctl_feat_i | input | 1 | Extended hypervisor control feature present |
| ext_ctl_en_i | input | 1 | Extended hypervisor control enabled |
| no_xs_ctl_i | input | 1 | Hypervisor asks lower-level invalidations to skip exempt entries |
| vmid_i | input | 16 | Current virtual-machine identifier |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_kind_o | output | 3 | Verdict code (R1) |
| trap_src_o | output | 3 | Winning trap control index plus 1, 0 if no trap |
| syndrome_o | output | 6 | Trap syndrome code |
| regime_o | output | 2 | 0 none, 1 lower, 2 highest |
| vmid_valid_o | output | 1 | VMID qualifies the invalidation |
| vmid_o | output | 16 | VMID to match |
| excl_xs_o | output | 1 | Leave entries exempt from extended-sync |
| asid_o | output | 8 | Address-space identifier to match |

## Verification
The bench builds the block with its default parameters: an 8-bit address-space identifier, a 16-bit virtual-machine identifier and a 6-bit syndrome. At these sizes every combination of the six trap controls, the hypervisor state and the hypervisor enable can be swept at level 1. The sweep exercises every position in the priority chain. All sixteen feature-bit combinations are also tried in both hypervisor states. After that, a long random run mixes matching and non-matching encodings and leaves random idle gaps, so that the hold behaviour between requests is exercised.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int NUM_TRAP = 6;
  localparam int SRC_W    = 3;
  // style of each trap control in priority order, 1 = 32-bit hypervisor
  localparam logic [NUM_TRAP-1:0] TRAP_IS32 = 6'b110010;

  typedef enum logic [2:0] {
    RES_NOMATCH = 3'd0,
    RES_UNDEF   = 3'd1,
    RES_TRAP64  = 3'd2,
    RES_TRAP32  = 3'd3,
    RES_EXEC    = 3'd4
  } res_kind_e;

  typedef enum logic [1:0] {
    RGM_NONE  = 2'd0,
    RGM_LOWER = 2'd1,
    RGM_HIGH  = 2'd2
  } regime_e;
endpackage

// File: rtl/tlbm_enc_match.sv
module tlbm_enc_match #(
  parameter logic [3:0] M_COPROC = 4'b1111,
  parameter logic [2:0] M_OPC1   = 3'b000,
  parameter logic [3:0] M_CRN    = 4'b1000,
  parameter logic [3:0] M_CRM    = 4'b0011,
  parameter logic [2:0] M_OPC2   = 3'b010
) (
  input  logic [3:0] coproc_i,
  input  logic [2:0] opc1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] opc2_i,
  output logic       hit_o
);
  logic [4:0] fld_ok;
  assign fld_ok[0] = (coproc_i == M_COPROC);
  assign fld_ok[1] = (opc1_i   == M_OPC1);
  assign fld_ok[2] = (crn_i    == M_CRN);
  assign fld_ok[3] = (crm_i    == M_CRM);
  assign fld_ok[4] = (opc2_i   == M_OPC2);
  assign hit_o = &fld_ok;
endmodule

// File: rtl/tlbm_trap_chain.sv
module tlbm_trap_chain
  import tlbm_pkg::*;
(
  input  logic                enable_i,
  input  logic                hyp_is32_i,
  input  logic [NUM_TRAP-1:0] ctl_i,
  output logic                hit_o,
  output logic                is32_o,
  output logic [SRC_W-1:0]    src_o
);
  logic [NUM_TRAP-1:0] armed;

  for (genvar g = 0; g < NUM_TRAP; g++) begin : g_arm
    assign armed[g] = enable_i & ctl_i[g] & (TRAP_IS32[g] == hyp_is32_i);
  end

  // lowest index wins
  always_comb begin
    hit_o  = 1'b0;
    is32_o = 1'b0;
    src_o  = '0;
    for (int i = NUM_TRAP - 1; i >= 0; i--) begin
      if (armed[i]) begin
        hit_o  = 1'b1;
        is32_o = TRAP_IS32[i];
        src_o  = SRC_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/tlbm_exec_attr.sv
module tlbm_exec_attr
  import tlbm_pkg::*;
(
  input  logic [1:0] cur_el_i,
  input  logic       hyp_is32_i,
  input  logic       xs_feat_i,
  input  logic       ext_ctl_feat_i,
  input  logic       ext_ctl_en_i,
  input  logic       no_xs_ctl_i,
  output regime_e    regime_o,
  output logic       vmid_valid_o,
  output logic       excl_xs_o
);
  logic el1_skip;
  assign el1_skip = xs_feat_i & ext_ctl_feat_i & ext_ctl_en_i & no_xs_ctl_i & ~hyp_is32_i;

  always_comb begin
    regime_o     = RGM_NONE;
    vmid_valid_o = 1'b0;
    excl_xs_o    = 1'b0;
    unique case (cur_el_i)
      2'd1: begin
        regime_o     = RGM_LOWER;
        vmid_valid_o = 1'b1;
        excl_xs_o    = el1_skip;
      end
      2'd2: begin
        regime_o     = RGM_LOWER;
        vmid_valid_o = 1'b1;
      end
      2'd3: regime_o = RGM_HIGH;
      default: ;
    endcase
  end
endmodule

// File: rtl/tlbm_access_arb.sv
module tlbm_access_arb
  import tlbm_pkg::*;
#(
  parameter int          OPND_W   = 32,
  parameter int          ASID_W   = 8,
  parameter int          VMID_W   = 16,
  parameter int          SYN_W    = 6,
  parameter logic [5:0]  TRAP_SYN = 6'h03
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [3:0]          coproc_i,
  input  logic [2:0]          opc1_i,
  input  logic [3:0]          crn_i,
  input  logic [3:0]          crm_i,
  input  logic [2:0]          opc2_i,
  input  logic [OPND_W-1:0]   operand_i,
  input  logic [1:0]          cur_el_i,
  input  logic                hyp_en_i,
  input  logic                hyp_is32_i,
  input  logic [5:0]          trap_ctl_i,
  input  logic                xs_feat_i,
  input  logic                ext_ctl_feat_i,
  input  logic                ext_ctl_en_i,
  input  logic                no_xs_ctl_i,
  input  logic [VMID_W-1:0]   vmid_i,
  output logic                rsp_valid_o,
  output logic [2:0]          rsp_kind_o,
  output logic [2:0]          trap_src_o,
  output logic [SYN_W-1:0]    syndrome_o,
  output logic [1:0]          regime_o,
  output logic                vmid_valid_o,
  output logic [VMID_W-1:0]   vmid_o,
  output logic                excl_xs_o,
  output logic [ASID_W-1:0]   asid_o
);
  localparam logic [SYN_W-1:0] SYN_CODE = SYN_W'(TRAP_SYN);

  logic             enc_hit;
  logic             trap_hit, trap_is32;
  logic [SRC_W-1:0] trap_src;
  regime_e          ex_regime;
  logic             ex_vmid_v, ex_excl;

  tlbm_enc_match u_match (
    .coproc_i (coproc_i),
    .opc1_i   (opc1_i),
    .crn_i    (crn_i),
    .crm_i    (crm_i),
    .opc2_i   (opc2_i),
    .hit_o    (enc_hit)
  );

  // trap controls only consulted at level 1 with hypervisor enabled
  tlbm_trap_chain u_chain (
    .enable_i   (hyp_en_i && cur_el_i == 2'd1),
    .hyp_is32_i (hyp_is32_i),
    .ctl_i      (trap_ctl_i),
    .hit_o      (trap_hit),
    .is32_o     (trap_is32),
    .src_o      (trap_src)
  );

  tlbm_exec_attr u_attr (
    .cur_el_i       (cur_el_i),
    .hyp_is32_i     (hyp_is32_i),
    .xs_feat_i      (xs_feat_i),
    .ext_ctl_feat_i (ext_ctl_feat_i),
    .ext_ctl_en_i   (ext_ctl_en_i),
    .no_xs_ctl_i    (no_xs_ctl_i),
    .regime_o       (ex_regime),
    .vmid_valid_o   (ex_vmid_v),
    .excl_xs_o      (ex_excl)
  );

  res_kind_e         kind_d;
  logic [SRC_W-1:0]  src_d;
  logic [SYN_W-1:0]  syn_d;
  regime_e           rgm_d;
  logic              vv_d, xs_d;
  logic [VMID_W-1:0] vmid_d;
  logic [ASID_W-1:0] asid_d;

  always_comb begin
    kind_d = RES_NOMATCH;
    src_d  = '0;
    syn_d  = '0;
    rgm_d  = RGM_NONE;
    vv_d   = 1'b0;
    xs_d   = 1'b0;
    vmid_d = '0;
    asid_d = '0;
    if (enc_hit) begin
      asid_d = operand_i[ASID_W-1:0];
      if (cur_el_i == 2'd0) begin
        kind_d = RES_UNDEF;
      end else if (trap_hit) begin
        kind_d = trap_is32 ? RES_TRAP32 : RES_TRAP64;
        src_d  = trap_src;
        syn_d  = SYN_CODE;
      end else begin
        kind_d = RES_EXEC;
        rgm_d  = ex_regime;
        vv_d   = ex_vmid_v;
        xs_d   = ex_excl;
        vmid_d = ex_vmid_v ? vmid_i : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_kind_o   <= RES_NOMATCH;
      trap_src_o   <= '0;
      syndrome_o   <= '0;
      regime_o     <= RGM_NONE;
      vmid_valid_o <= 1'b0;
      vmid_o       <= '0;
      excl_xs_o    <= 1'b0;
      asid_o       <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_kind_o   <= kind_d;
        trap_src_o   <= src_d;
        syndrome_o   <= syn_d;
        regime_o     <= rgm_d;
        vmid_valid_o <= vv_d;
        vmid_o       <= vmid_d;
        excl_xs_o    <= xs_d;
        asid_o       <= asid_d;
      end
    end
  end
endmodule

module tlbm_access_arb_chk #(
  parameter int         VMID_W   = 16,
  parameter int         SYN_W    = 6,
  parameter logic [5:0] TRAP_SYN = 6'h03
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [3:0]        coproc_i,
  input logic [2:0]        opc1_i,
  input logic [3:0]        crn_i,
  input logic [3:0]        crm_i,
  input logic [2:0]        opc2_i,
  input logic [1:0]        cur_el_i,
  input logic              hyp_en_i,
  input logic              rsp_valid_o,
  input logic [2:0]        rsp_kind_o,
  input logic [2:0]        trap_src_o,
  input logic [SYN_W-1:0]  syndrome_o,
  input logic [1:0]        regime_o,
  input logic              vmid_valid_o,
  input logic [VMID_W-1:0] vmid_o,
  input logic              excl_xs_o
);
  logic enc_ok;
  assign enc_ok = coproc_i == 4'b1111 && opc1_i == 3'b000 && crn_i == 4'b1000 &&
                  crm_i == 4'b0011 && opc2_i == 3'b010;

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R2
  el0_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && enc_ok && cur_el_i == 2'd0) |=> rsp_kind_o == 3'd1);
  // R4
  hyp_off_no_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && enc_ok && !hyp_en_i && cur_el_i != 2'd0) |=> rsp_kind_o == 3'd4);
  // R5
  trap_syndrome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && (rsp_kind_o == 3'd2 || rsp_kind_o == 3'd3)) |-> syndrome_o == SYN_W'(TRAP_SYN));
  // R5
  other_syndrome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o != 3'd2 && rsp_kind_o != 3'd3) |-> syndrome_o == '0);
  // R3
  trap_src_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && trap_src_o != 3'd0) |-> (rsp_kind_o == 3'd2 || rsp_kind_o == 3'd3));
  // R8
  high_no_vmid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && regime_o == 2'd2) |-> (!vmid_valid_o && vmid_o == '0 && !excl_xs_o));
  // R1
  nomatch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !enc_ok) |=> (rsp_kind_o == 3'd0 && regime_o == 2'd0 && !vmid_valid_o));
endmodule

bind tlbm_access_arb tlbm_access_arb_chk #(
  .VMID_W(VMID_W), .SYN_W(SYN_W), .TRAP_SYN(TRAP_SYN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .coproc_i(coproc_i), .opc1_i(opc1_i), .crn_i(crn_i), .crm_i(crm_i), .opc2_i(opc2_i),
  .cur_el_i(cur_el_i), .hyp_en_i(hyp_en_i),
  .rsp_valid_o(rsp_valid_o), .rsp_kind_o(rsp_kind_o), .trap_src_o(trap_src_o),
  .syndrome_o(syndrome_o), .regime_o(regime_o), .vmid_valid_o(vmid_valid_o),
  .vmid_o(vmid_o), .excl_xs_o(excl_xs_o)
);

// File: tb/tlbm_access_arb_tb_top.sv
module tlbm_access_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  coproc = '0;
  logic [2:0]  opc1 = '0;
  logic [3:0]  crn = '0;
  logic [3:0]  crm = '0;
  logic [2:0]  opc2 = '0;
  logic [31:0] operand = '0;
  logic [1:0]  cur_el = '0;
  logic        hyp_en = 1'b0, hyp_is32 = 1'b0;
  logic [5:0]  trap_ctl = '0;
  logic        xs_feat = 1'b0, ext_feat = 1'b0, ext_en = 1'b0, no_xs = 1'b0;
  logic [15:0] vmid = '0;

  logic        rsp_valid;
  logic [2:0]  rsp_kind, trap_src;
  logic [5:0]  syndrome;
  logic [1:0]  regime;
  logic        vmid_valid, excl_xs;
  logic [15:0] vmid_out;
  logic [7:0]  asid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // expected response
  int e_valid = 0, e_kind = 0, e_src = 0, e_syn = 0, e_rgm = 0, e_vv = 0, e_vmid = 0, e_xs = 0, e_asid = 0;
  string e_tag = "R10";

  always #10 clk = ~clk;

  tlbm_access_arb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
    .coproc_i(coproc), .opc1_i(opc1), .crn_i(crn), .crm_i(crm), .opc2_i(opc2),
    .operand_i(operand), .cur_el_i(cur_el), .hyp_en_i(hyp_en), .hyp_is32_i(hyp_is32),
    .trap_ctl_i(trap_ctl), .xs_feat_i(xs_feat), .ext_ctl_feat_i(ext_feat),
    .ext_ctl_en_i(ext_en), .no_xs_ctl_i(no_xs), .vmid_i(vmid),
    .rsp_valid_o(rsp_valid), .rsp_kind_o(rsp_kind), .trap_src_o(trap_src),
    .syndrome_o(syndrome), .regime_o(regime), .vmid_valid_o(vmid_valid),
    .vmid_o(vmid_out), .excl_xs_o(excl_xs), .asid_o(asid)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural model, evaluated on the inputs about to be sampled
  task automatic model();
    bit [5:0] style32 = 6'b110010;
    bit match;
    e_valid = req_valid;
    if (!req_valid) return;
    match = (coproc == 4'hF) && (opc1 == 3'd0) && (crn == 4'h8) && (crm == 4'h3) && (opc2 == 3'd2);
    e_kind = 0; e_src = 0; e_syn = 0; e_rgm = 0; e_vv = 0; e_vmid = 0; e_xs = 0; e_asid = 0;
    if (!match) begin
      e_tag = "R1";
      return;
    end
    e_asid = operand[7:0];
    if (cur_el == 0) begin
      e_kind = 1; e_tag = "R2";
    end else if (cur_el == 1) begin
      if (hyp_en) begin
        for (int i = 0; i < 6; i++) begin
          if (e_src == 0 && trap_ctl[i] && style32[i] == hyp_is32) begin
            e_src = i + 1;
            e_kind = style32[i] ? 3 : 2;
            e_syn = 3;
          end
        end
      end
      if (e_src != 0) e_tag = "R3";
      else begin
        e_tag = (trap_ctl != 0) ? "R4" : "R6";
        e_kind = 4; e_rgm = 1; e_vv = 1; e_vmid = vmid;
        e_xs = (xs_feat && ext_feat && ext_en && no_xs && !hyp_is32) ? 1 : 0;
      end
    end else if (cur_el == 2) begin
      e_tag = "R7"; e_kind = 4; e_rgm = 1; e_vv = 1; e_vmid = vmid;
    end else begin
      e_tag = "R8"; e_kind = 4; e_rgm = 2;
    end
  endtask

  task automatic compare();
    chk("R9", "rsp_valid", rsp_valid, e_valid);
    chk(e_tag, "kind", rsp_kind, e_kind);
    chk(e_tag, "trap_src", trap_src, e_src);
    chk("R5", "syndrome", syndrome, e_syn);
    chk(e_tag, "regime", regime, e_rgm);
    chk(e_tag, "vmid_valid", vmid_valid, e_vv);
    chk(e_tag, "vmid", vmid_out, e_vmid);
    chk(e_tag, "excl_xs", excl_xs, e_xs);
    chk("R9", "asid", asid, e_asid);
  endtask

  // inputs are set after a negedge; sample the result one edge later
  task automatic step();
    model();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic set_enc_ok();
    coproc = 4'hF; opc1 = 3'd0; crn = 4'h8; crm = 4'h3; opc2 = 3'd2;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    step();

    // R1: each field off by one bit
    req_valid = 1'b1; cur_el = 2'd2; operand = 32'h1234_56A5; vmid = 16'hBEEF;
    for (int f = 0; f < 5; f++) begin
      set_enc_ok();
      case (f)
        0: coproc = 4'hE;
        1: opc1 = 3'd1;
        2: crn = 4'h9;
        3: crm = 4'h2;
        default: opc2 = 3'd3;
      endcase
      step();
    end
    set_enc_ok();

    // R2: level 0 ignores everything
    cur_el = 2'd0; hyp_en = 1'b1; trap_ctl = 6'h3F; step();
    hyp_is32 = 1'b1; step();

    // R3 R4: full sweep at level 1
    cur_el = 2'd1;
    for (int m = 0; m < 64; m++) begin
      for (int s = 0; s < 4; s++) begin
        trap_ctl = m[5:0]; hyp_is32 = s[0]; hyp_en = s[1];
        operand = 32'(m * 7 + s); vmid = 16'(m * 131 + s);
        step();
      end
    end

    // R6: exclude-flag qualifiers
    trap_ctl = '0; hyp_en = 1'b1;
    for (int c = 0; c < 32; c++) begin
      {hyp_is32, xs_feat, ext_feat, ext_en, no_xs} = c[4:0];
      step();
    end

    // R7 R8: upper levels with traps and qualifiers set
    trap_ctl = 6'h3F; {xs_feat, ext_feat, ext_en, no_xs} = 4'hF; hyp_is32 = 1'b0;
    cur_el = 2'd2; step();
    cur_el = 2'd3; step();
    hyp_en = 1'b0; step();

    // R9: hold between requests, random traffic
    for (int n = 0; n < 3000; n++) begin
      req_valid = ($urandom % 3) != 0;
      if ($urandom % 2) set_enc_ok();
      else {coproc, opc1, crn, crm, opc2} = 18'($urandom);
      operand = $urandom; vmid = 16'($urandom); cur_el = 2'($urandom);
      {hyp_en, hyp_is32, xs_feat, ext_feat, ext_en, no_xs} = 6'($urandom);
      trap_ctl = ($urandom % 4 == 0) ? 6'($urandom) : 6'(1 << ($urandom % 7));
      step();
    end
    req_valid = 1'b0;
    step();
    step();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule